// File: doc/BRIEF.md
# Keyed-Sequence Software Watchdog

This block guards a processor against runaway code. A down-counter runs on the system clock, either on every cycle or once every 2048 cycles through a prescaler. Software must service it before it reaches zero. When the count is exhausted, the block raises a one-cycle request. Depending on a control bit, that request goes either to the system reset logic or to the non-maskable interrupt input.

Servicing is protected by a two-word key. Writing a single value to the service port does nothing. The counter reloads only when the arming word `0x556C` is followed by the firing word `0xAA39`. Any number of cycles and other writes may come between the two words. The configuration port sets the enable, the response select, the prescale enable and the reload value. It accepts exactly one write after reset, so runaway code cannot switch the watchdog off later.

The key checker has two states:
- `KS_WAIT_ARM`: `0x556C` moves it to `KS_WAIT_FIRE`, and every other value leaves it where it is.
- `KS_WAIT_FIRE`: `0xAA39` completes the service and returns it to `KS_WAIT_ARM`. Any other value, including a second `0x556C`, returns it to `KS_WAIT_ARM` with no reload.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is enabled, in reset-response mode, with the prescaler off and the reload value 0xFFFF. `count_value` reads 0xFFFF and falls by one on each clock.
- R2: A completed key pair (`svc_data` 0x556C on one service write, then 0xAA39 on a later service write) loads the reload value into the counter. The new count is visible on the clock after the second write.
- R3: A service value other than 0x556C while waiting for the arming word leaves the checker waiting and does not reload. Any value other than 0xAA39 after the arming word (0x556C included) drops back to waiting for the arming word, without a reload.
- R4: Any number of idle cycles may separate the two key words.
- R5: While enabled, the counter falls by one per tick. On a tick at zero it raises an expiry and reloads from the reload value.
- R6: In reset mode (`cfg_nmi_sel`=0), an expiry gives a one-cycle `rst_req` pulse on the clock after the tick at zero, and `nmi_req` stays low.
- R7: In interrupt mode (`cfg_nmi_sel`=1), an expiry gives a one-cycle `nmi_req` pulse instead, and counting continues from the reload value.
- R8: With `cfg_prescale`=1, one tick occurs every 2048 clocks. A completed service clears the prescaler phase.
- R9: Only the first `cfg_wr` after reset is accepted. Every later configuration write is ignored.
- R10: A configuration write does not change the running count. A new reload value is used only at the next reload.
- R11: With the enable clear, the counter holds its value and no request is raised.
- R12: If a service completes in the same cycle as a tick at zero, the service wins: the counter takes the reload value and no request pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe (one-time) |
| cfg_enable | input | 1 | Enable value to store |
| cfg_nmi_sel | input | 1 | Response select to store: 1 selects interrupt, 0 selects reset |
| cfg_prescale | input | 1 | Divide-by-2048 enable to store |
| cfg_reload | input | 16 | Reload value to store |
| svc_wr | input | 1 | Service write strobe |
| svc_data | input | 16 | Service write value |
| count_value | output | 16 | Current counter value |
| rst_req | output | 1 | One-cycle reset request |
| nmi_req | output | 1 | One-cycle interrupt request |

## Verification
Two events can fall in the same cycle: the firing key word can complete a service on the very tick that finds the counter at zero.

The bench provokes this by sending the arming word early. It then watches `count_value` on falling edges and drives the firing word at the moment the count reads zero.

The check passes only if the counter shows the reload value one clock later and neither request line pulses. A behavioural model is compared on every clock and judges the same case.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int          KEY_W    = 16;
    localparam logic [15:0] KEY_ARM  = 16'h556C;
    localparam logic [15:0] KEY_FIRE = 16'hAA39;

    typedef enum logic {
        KS_WAIT_ARM  = 1'b0,
        KS_WAIT_FIRE = 1'b1
    } key_state_e;
endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg #(
    parameter int          CNT_W       = 16,
    parameter logic [15:0] RELOAD_INIT = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             wr_enable,
    input  logic             wr_nmi_sel,
    input  logic             wr_prescale,
    input  logic [CNT_W-1:0] wr_reload,
    output logic             enable,
    output logic             nmi_sel,
    output logic             prescale,
    output logic [CNT_W-1:0] reload,
    output logic             locked
);
    // Only the first write after reset lands; the lock bit then blocks the rest.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable   <= 1'b1;
            nmi_sel  <= 1'b0;
            prescale <= 1'b0;
            reload   <= CNT_W'(RELOAD_INIT);
            locked   <= 1'b0;
        end else if (wr && !locked) begin
            enable   <= wr_enable;
            nmi_sel  <= wr_nmi_sel;
            prescale <= wr_prescale;
            reload   <= wr_reload;
            locked   <= 1'b1;
        end
    end
endmodule

// File: rtl/wdog_key_fsm.sv
module wdog_key_fsm
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [KEY_W-1:0] data,
    output logic             done
);
    key_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KS_WAIT_ARM;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        done    = 1'b0;
        if (wr) begin
            unique case (state_q)
                KS_WAIT_ARM: begin
                    if (data == KEY_ARM) state_d = KS_WAIT_FIRE;
                end
                KS_WAIT_FIRE: begin
                    // Any second word ends the attempt; only the firing word services.
                    state_d = KS_WAIT_ARM;
                    done    = (data == KEY_FIRE);
                end
                default: state_d = KS_WAIT_ARM;
            endcase
        end
    end
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int PRE_W = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    logic [PRE_W-1:0] phase_q;

    assign tick = &phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     phase_q <= '0;
        else if (clear) phase_q <= '0;
        else if (run)   phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
    parameter int          CNT_W       = 16,
    parameter logic [15:0] RELOAD_INIT = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             service,
    input  logic             nmi_sel,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             rst_req,
    output logic             nmi_req
);
    logic at_zero;
    logic expire;

    assign at_zero = (count == '0);
    // A service landing on the zero tick wins, so no expiry is raised.
    assign expire  = enable && tick && at_zero && !service;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= CNT_W'(RELOAD_INIT);
        end else if (service) begin
            count <= reload;
        end else if (enable && tick) begin
            count <= at_zero ? reload : count - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
            nmi_req <= 1'b0;
        end else begin
            rst_req <= expire && !nmi_sel;
            nmi_req <= expire &&  nmi_sel;
        end
    end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
    parameter int          CNT_W       = 16,
    parameter int          PRE_W       = 11,
    parameter logic [15:0] RELOAD_INIT = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_enable,
    input  logic             cfg_nmi_sel,
    input  logic             cfg_prescale,
    input  logic [CNT_W-1:0] cfg_reload,
    input  logic             svc_wr,
    input  logic [15:0]      svc_data,
    output logic [CNT_W-1:0] count_value,
    output logic             rst_req,
    output logic             nmi_req
);
    logic             en_q, nmi_q, pre_q, locked_q;
    logic [CNT_W-1:0] reload_q;
    logic             svc_done;
    logic             pre_tick;
    logic             cnt_tick;

    wdog_cfg_reg #(.CNT_W(CNT_W), .RELOAD_INIT(RELOAD_INIT)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (cfg_wr),
        .wr_enable   (cfg_enable),
        .wr_nmi_sel  (cfg_nmi_sel),
        .wr_prescale (cfg_prescale),
        .wr_reload   (cfg_reload),
        .enable      (en_q),
        .nmi_sel     (nmi_q),
        .prescale    (pre_q),
        .reload      (reload_q),
        .locked      (locked_q)
    );

    wdog_key_fsm u_key (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (svc_wr),
        .data  (svc_data),
        .done  (svc_done)
    );

    wdog_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en_q && pre_q),
        .clear (svc_done),
        .tick  (pre_tick)
    );

    assign cnt_tick = pre_q ? pre_tick : 1'b1;

    wdog_down_counter #(.CNT_W(CNT_W), .RELOAD_INIT(RELOAD_INIT)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (en_q),
        .tick    (cnt_tick),
        .service (svc_done),
        .nmi_sel (nmi_q),
        .reload  (reload_q),
        .count   (count_value),
        .rst_req (rst_req),
        .nmi_req (nmi_req)
    );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count,
    input logic             rst_req,
    input logic             nmi_req,
    input logic             en,
    input logic             pre,
    input logic             nmi_sel,
    input logic [CNT_W-1:0] reload,
    input logic             locked,
    input logic             svc_done
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    p_reload_on_service_r2: assert property (@(posedge clk) disable iff (!rst_n)
        svc_done |=> count == $past(reload));

    p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !pre && !svc_done && count != '0) |=> count == $past(count) - ONE);

    p_rst_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_rst_after_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(count) == '0 && !$past(nmi_sel)));

    p_nmi_after_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> ($past(count) == '0 && $past(nmi_sel)));

    p_exclusive_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && nmi_req));

    p_locked_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(en) && $stable(nmi_sel) && $stable(pre) && $stable(reload)));

    p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !svc_done) |=> ($stable(count) && !rst_req && !nmi_req));

    p_service_beats_expiry_r12: assert property (@(posedge clk) disable iff (!rst_n)
        svc_done |=> (!rst_req && !nmi_req));
endmodule

bind keyed_watchdog wdog_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (count_value),
    .rst_req  (rst_req),
    .nmi_req  (nmi_req),
    .en       (en_q),
    .pre      (pre_q),
    .nmi_sel  (nmi_q),
    .reload   (reload_q),
    .locked   (locked_q),
    .svc_done (svc_done)
);

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_enable = 1'b0, cfg_nmi_sel = 1'b0, cfg_prescale = 1'b0;
    logic [15:0] cfg_reload = '0;
    logic        svc_wr = 1'b0;
    logic [15:0] svc_data = '0;
    logic [15:0] count_value;
    logic        rst_req, nmi_req;

    int checks = 0;
    int errors = 0;
    int rst_seen = 0;
    int nmi_seen = 0;
    int cycles = 0;

    // behavioural reference state
    int m_en, m_nmi, m_pre_en, m_reload, m_locked, m_armed, m_cnt, m_pre, m_rst, m_nmiq;

    always #5 clk = ~clk;

    keyed_watchdog uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable),
        .cfg_nmi_sel(cfg_nmi_sel), .cfg_prescale(cfg_prescale), .cfg_reload(cfg_reload),
        .svc_wr(svc_wr), .svc_data(svc_data), .count_value(count_value),
        .rst_req(rst_req), .nmi_req(nmi_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 1; m_nmi = 0; m_pre_en = 0; m_reload = 65535; m_locked = 0;
            m_armed = 0; m_cnt = 65535; m_pre = 0; m_rst = 0; m_nmiq = 0;
        end else begin
            int tick, done, expd;
            tick = (!m_pre_en || m_pre == 2047) ? 1 : 0;
            done = (svc_wr && m_armed && svc_data == 16'hAA39) ? 1 : 0;
            expd = (m_en && tick && m_cnt == 0 && !done) ? 1 : 0;
            m_rst  = expd && !m_nmi;
            m_nmiq = expd && m_nmi;
            if (done) m_pre = 0;
            else if (m_en && m_pre_en) m_pre = (m_pre + 1) % 2048;
            if (done) m_cnt = m_reload;
            else if (m_en && tick) m_cnt = (m_cnt == 0) ? m_reload : m_cnt - 1;
            if (svc_wr) m_armed = (!m_armed && svc_data == 16'h556C) ? 1 : 0;
            if (cfg_wr && !m_locked) begin
                m_en = cfg_enable; m_nmi = cfg_nmi_sel; m_pre_en = cfg_prescale;
                m_reload = cfg_reload; m_locked = 1;
            end
        end
    end

    // compare against the model on every falling edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(count_value == m_cnt[15:0], "R5 count model", count_value, m_cnt);
            check(rst_req == m_rst[0], "R6 rst_req model", rst_req, m_rst);
            check(nmi_req == m_nmiq[0], "R7 nmi_req model", nmi_req, m_nmiq);
            if (rst_req) rst_seen++;
            if (nmi_req) nmi_seen++;
        end
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog timeout actual=%0d expected=0", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rst_seen = 0;
        nmi_seen = 0;
    endtask

    task automatic cfg_write(input bit en, input bit nmi, input bit pre, input logic [15:0] rl);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_enable = en; cfg_nmi_sel = nmi; cfg_prescale = pre; cfg_reload = rl;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic svc_write(input logic [15:0] v);
        @(negedge clk);
        svc_wr = 1'b1; svc_data = v;
        @(negedge clk);
        svc_wr = 1'b0;
    endtask

    task automatic service();
        svc_write(16'h556C);
        svc_write(16'hAA39);
    endtask

    initial begin
        // R1: reset state
        do_reset();
        check(count_value == 16'hFFFF, "R1 count after reset", count_value, 65535);
        check(!rst_req && !nmi_req, "R1 no request after reset", rst_req, 0);
        repeat (10) @(negedge clk);
        check(count_value == 16'hFFF5, "R1 counts down by default", count_value, 65525);

        // R9/R10: first write accepted, count not disturbed
        cfg_write(1'b1, 1'b1, 1'b0, 16'd40);
        check(count_value > 16'd1000, "R10 cfg write keeps running count", count_value, 65520);

        // R3: wrong sequences do not reload
        svc_write(16'hAA39);
        check(count_value > 16'd1000, "R3 fire word alone ignored", count_value, 65500);
        svc_write(16'h556C); svc_write(16'h1234); svc_write(16'hAA39);
        check(count_value > 16'd1000, "R3 bad second word drops sequence", count_value, 65500);
        svc_write(16'h556C); svc_write(16'h556C); svc_write(16'hAA39);
        check(count_value > 16'd1000, "R3 repeated arm word drops sequence", count_value, 65500);

        // R2/R4: proper pair with a gap
        svc_write(16'h556C);
        repeat (7) @(negedge clk);
        svc_write(16'hAA39);
        check(count_value == 16'd40, "R2 R4 reload after gapped pair", count_value, 40);

        // R7: interrupt mode keeps running; R9: later write ignored
        cfg_write(1'b0, 1'b0, 1'b0, 16'd5);
        repeat (100) @(negedge clk);
        check(nmi_seen >= 2, "R7 nmi pulses repeat", nmi_seen, 2);
        check(rst_seen == 0, "R9 second cfg write ignored", rst_seen, 0);
        check(count_value <= 16'd40, "R9 reload unchanged", count_value, 40);

        // R6: reset mode
        do_reset();
        cfg_write(1'b1, 1'b0, 1'b0, 16'd10);
        service();
        repeat (15) @(negedge clk);
        check(rst_seen == 1, "R6 one rst pulse", rst_seen, 1);
        check(nmi_seen == 0, "R6 no nmi in reset mode", nmi_seen, 0);

        // R11: disabled holds
        do_reset();
        cfg_write(1'b0, 1'b0, 1'b0, 16'd3);
        begin
            logic [15:0] held;
            held = count_value;
            repeat (100) @(negedge clk);
            check(count_value == held, "R11 count holds when disabled", count_value, held);
            check(rst_seen == 0 && nmi_seen == 0, "R11 no request when disabled", rst_seen + nmi_seen, 0);
        end

        // R8: prescaler
        do_reset();
        cfg_write(1'b1, 1'b1, 1'b1, 16'd1);
        service();
        repeat (3000) @(negedge clk);
        check(count_value == 16'd0, "R8 one tick per 2048 clocks", count_value, 0);
        check(nmi_seen == 0, "R8 no early expiry", nmi_seen, 0);
        service();
        repeat (3000) @(negedge clk);
        check(count_value == 16'd0 && nmi_seen == 0, "R8 service clears prescaler", nmi_seen, 0);
        repeat (2000) @(negedge clk);
        check(nmi_seen == 1, "R8 expiry after two prescaled ticks", nmi_seen, 1);

        // R12: service coinciding with zero tick
        do_reset();
        cfg_write(1'b1, 1'b1, 1'b0, 16'd10);
        service();
        svc_write(16'h556C);
        while (count_value != 16'd0) @(negedge clk);
        svc_wr = 1'b1; svc_data = 16'hAA39;
        @(negedge clk);
        svc_wr = 1'b0;
        check(count_value == 16'd10, "R12 service wins at zero", count_value, 10);
        check(!nmi_req && !rst_req, "R12 no pulse on coincidence", nmi_req, 0);
        repeat (3) @(negedge clk);
        check(nmi_seen == 0, "R12 no later pulse", nmi_seen, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule